// File: doc/BRIEF.md
# Serial Link Word Framer

This block packs everything a serial link transmitter sends during one pixel period into a single 32-bit word. On every enabled pixel clock edge it captures a 29-bit parallel payload, one side-channel bit that carries either encoded audio or a spare control pin, and one forward control-channel bit. It then closes the word with a parity bit, so that a downstream serializer can shift it onto the line without any further formatting.

One payload position, bit 27, has two possible sources. A select input chooses between the parallel video lane and an external control pin. The side-channel bit is governed by an audio mode register. The register comes out of reset with audio active, and a one-cycle write strobe can change it. While audio is inactive, the side-channel slot carries a control pin instead of the audio encoder bit. The framer holds its last word whenever its enable input is low.

Top module: `link_word_framer`

## Requirements
- R1: Word bits 26:0 and 28 equal the matching bits of `pix_data` sampled at the capturing edge.
- R2: Word bit 27 equals `alt_pin` when `alt_sel` is 1, and `pix_data[27]` when `alt_sel` is 0.
- R3: While the audio mode is active, word bit 29 equals `aud_bit`.
- R4: While the audio mode is inactive, word bit 29 equals `ctl_pin`, and `aud_bit` has no effect on the word.
- R5: The audio mode is active (1) after reset. A cycle with `aud_cfg_wr` high loads `aud_cfg_val` (1 = active). The new mode applies to words captured from the next edge onward, and the word captured at the write edge still uses the old mode.
- R6: Word bit 30 equals `fwd_bit`.
- R7: Word bit 31 makes the count of ones over all 32 word bits even.
- R8: An edge with `frame_en` high presents a new word with `out_valid` high after that edge. An edge with `frame_en` low drives `out_valid` low and leaves `out_word` unchanged.
- R9: While `rst_n` is low, `out_word` is all zeros and `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_en | input | 1 | Capture a word on this edge |
| pix_data | input | 29 | Parallel payload bits |
| alt_sel | input | 1 | 1 = bit 27 comes from `alt_pin` |
| alt_pin | input | 1 | Alternate source for payload bit 27 |
| aud_cfg_wr | input | 1 | Load strobe for the audio mode |
| aud_cfg_val | input | 1 | Audio mode value to load, 1 = active |
| aud_bit | input | 1 | Encoded audio stream bit |
| ctl_pin | input | 1 | Control pin used when audio is inactive |
| fwd_bit | input | 1 | Forward control-channel bit |
| out_word | output | 32 | Registered link word |
| out_valid | output | 1 | Word presented on this cycle |

## Verification
The assertions assume that all inputs are synchronous to `clk` and settle between edges. They also assume that a configuration write and a word capture may fall in the same cycle, and they allow for this by relating the mode register only to the previous cycle's strobe. The properties that look one edge back include `rst_n` in their antecedent, so a strobe or enable held during reset is not mistaken for a real one. The bench changes every input only at the falling edge. Its random mix enables capture on most cycles and writes the audio mode now and then, so both modes and the same-cycle write case occur many times.

// File: rtl/lwf_pkg.sv
package lwf_pkg;
  localparam int PAYLOAD_W = 29;
  localparam int ALT_POS   = 27;
  localparam int SIDE_W    = 2;
  localparam int WORD_W    = PAYLOAD_W + SIDE_W + 1;

  typedef struct packed {
    logic fwd;
    logic aud;
  } side_bits_t;
endpackage

// File: rtl/lwf_payload_mux.sv
module lwf_payload_mux #(
  parameter int PAYLOAD_W = lwf_pkg::PAYLOAD_W,
  parameter int ALT_POS   = lwf_pkg::ALT_POS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [PAYLOAD_W-1:0] pix_data,
  input  logic                 alt_sel,
  input  logic                 alt_pin,
  output logic [PAYLOAD_W-1:0] payload
);
  for (genvar i = 0; i < PAYLOAD_W; i++) begin : g_bit
    if (i == ALT_POS) begin : g_alt
      assign payload[i] = alt_sel ? alt_pin : pix_data[i];
    end else begin : g_pass
      assign payload[i] = pix_data[i];
    end
  end

  assert_alt_slot_pin_R2: assert property (@(posedge clk) disable iff (!rst_n)
    alt_sel |-> payload[ALT_POS] == alt_pin);
  assert_alt_slot_lane_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !alt_sel |-> payload[ALT_POS] == pix_data[ALT_POS]);
endmodule

// File: rtl/lwf_side_bits.sv
module lwf_side_bits (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 aud_cfg_wr,
  input  logic                 aud_cfg_val,
  input  logic                 aud_bit,
  input  logic                 ctl_pin,
  input  logic                 fwd_bit,
  output lwf_pkg::side_bits_t  side,
  output logic                 aud_active
);
  logic aud_mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          aud_mode_q <= 1'b1;
    else if (aud_cfg_wr) aud_mode_q <= aud_cfg_val;
  end

  assign aud_active = aud_mode_q;
  assign side.aud   = aud_mode_q ? aud_bit : ctl_pin;
  assign side.fwd   = fwd_bit;

  // R5: the mode register follows its strobe and holds otherwise
  assert_mode_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && aud_cfg_wr) |=> aud_active == $past(aud_cfg_val));
  assert_mode_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && !aud_cfg_wr) |=> $stable(aud_active));
endmodule

// File: rtl/lwf_word_reg.sv
module lwf_word_reg #(
  parameter int PAYLOAD_W = lwf_pkg::PAYLOAD_W,
  parameter int WORD_W    = PAYLOAD_W + 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 frame_en,
  input  logic [PAYLOAD_W-1:0] payload,
  input  lwf_pkg::side_bits_t  side,
  output logic [WORD_W-1:0]    out_word,
  output logic                 out_valid
);
  function automatic logic even_fill(input logic [WORD_W-2:0] body);
    logic p;
    p = 1'b0;
    for (int k = 0; k < WORD_W - 1; k++) p = p ^ body[k];
    return p;
  endfunction

  logic [WORD_W-2:0] body;
  logic              par_bit;

  assign body    = {side.fwd, side.aud, payload};
  assign par_bit = even_fill(body);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_word  <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= frame_en;
      if (frame_en) out_word <= {par_bit, body};
    end
  end

  assert_even_parity_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($countones(out_word) % 2) == 0);
  assert_capture_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && frame_en) |=> out_valid);
  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && !frame_en) |=> (!out_valid && $stable(out_word)));
endmodule

// File: rtl/link_word_framer.sv
module link_word_framer #(
  parameter int PAYLOAD_W = lwf_pkg::PAYLOAD_W,
  parameter int ALT_POS   = lwf_pkg::ALT_POS,
  localparam int WORD_W   = PAYLOAD_W + 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 frame_en,
  input  logic [PAYLOAD_W-1:0] pix_data,
  input  logic                 alt_sel,
  input  logic                 alt_pin,
  input  logic                 aud_cfg_wr,
  input  logic                 aud_cfg_val,
  input  logic                 aud_bit,
  input  logic                 ctl_pin,
  input  logic                 fwd_bit,
  output logic [WORD_W-1:0]    out_word,
  output logic                 out_valid
);
  logic [PAYLOAD_W-1:0] payload;
  lwf_pkg::side_bits_t  side;
  logic                 aud_active;

  lwf_payload_mux #(.PAYLOAD_W(PAYLOAD_W), .ALT_POS(ALT_POS)) u_payload (
    .clk(clk), .rst_n(rst_n), .pix_data(pix_data),
    .alt_sel(alt_sel), .alt_pin(alt_pin), .payload(payload));

  lwf_side_bits u_side (
    .clk(clk), .rst_n(rst_n), .aud_cfg_wr(aud_cfg_wr), .aud_cfg_val(aud_cfg_val),
    .aud_bit(aud_bit), .ctl_pin(ctl_pin), .fwd_bit(fwd_bit),
    .side(side), .aud_active(aud_active));

  lwf_word_reg #(.PAYLOAD_W(PAYLOAD_W), .WORD_W(WORD_W)) u_word (
    .clk(clk), .rst_n(rst_n), .frame_en(frame_en), .payload(payload),
    .side(side), .out_word(out_word), .out_valid(out_valid));

  assert_audio_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && frame_en && aud_active) |=> out_word[PAYLOAD_W] == $past(aud_bit));
  assert_ctl_fallback_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && frame_en && !aud_active) |=> out_word[PAYLOAD_W] == $past(ctl_pin));
  assert_fwd_slot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && frame_en) |=> out_word[PAYLOAD_W+1] == $past(fwd_bit));
endmodule

// File: tb/link_word_framer_bench.sv
module link_word_framer_bench;
  localparam int PW = 29;
  localparam time HALF = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_en = 1'b0;
  logic [PW-1:0] pix_data = '0;
  logic alt_sel = 1'b0, alt_pin = 1'b0;
  logic aud_cfg_wr = 1'b0, aud_cfg_val = 1'b0;
  logic aud_bit = 1'b0, ctl_pin = 1'b0, fwd_bit = 1'b0;
  logic [31:0] out_word;
  logic out_valid;

  int n_chk = 0, n_bad = 0;
  logic m_aud = 1'b1;
  logic [31:0] e_word = '0;
  logic e_valid = 1'b0;
  bit done = 0;

  always #HALF clk = ~clk;

  link_word_framer u_link_word_framer (
    .clk(clk), .rst_n(rst_n), .frame_en(frame_en), .pix_data(pix_data),
    .alt_sel(alt_sel), .alt_pin(alt_pin), .aud_cfg_wr(aud_cfg_wr),
    .aud_cfg_val(aud_cfg_val), .aud_bit(aud_bit), .ctl_pin(ctl_pin),
    .fwd_bit(fwd_bit), .out_word(out_word), .out_valid(out_valid));

  function automatic logic [31:0] model_word(input logic [PW-1:0] d, input logic sel,
      input logic pin, input logic aon, input logic a, input logic c, input logic f);
    logic [31:0] w;
    int ones;
    w = '0;
    for (int i = 0; i < PW; i++) w[i] = (i == 27 && sel) ? pin : d[i];
    w[29] = aon ? a : c;
    w[30] = f;
    ones = 0;
    for (int i = 0; i < 31; i++) ones += int'(w[i]);
    w[31] = (ones % 2 == 1);
    return w;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input string tag);
    @(posedge clk);
    if (frame_en) begin
      e_word  = model_word(pix_data, alt_sel, alt_pin, m_aud, aud_bit, ctl_pin, fwd_bit);
      e_valid = 1'b1;
    end else e_valid = 1'b0;
    if (aud_cfg_wr) m_aud = aud_cfg_val;
    @(negedge clk);
    chk({tag, " word"}, out_word, e_word);
    chk({tag, " valid (R8)"}, {31'b0, out_valid}, {31'b0, e_valid});
  endtask

  initial begin
    #(HALF * 2 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    chk("R9 reset word", out_word, 32'h0);
    chk("R9 reset valid", {31'b0, out_valid}, 32'h0);
    rst_n = 1'b1;

    // R5 default audio active, R3 audio slot
    frame_en = 1; pix_data = 29'h0ABC_1234; aud_bit = 1; ctl_pin = 0; fwd_bit = 1;
    step("R5 R3 R6 default audio");
    // R2 alternate pin into bit 27
    alt_sel = 1; alt_pin = 1; pix_data = '0;
    step("R2 alt pin");
    alt_sel = 1; alt_pin = 0; pix_data = '1;
    step("R2 alt pin low");
    alt_sel = 0; alt_pin = 0; pix_data = 29'h0800_0000;
    step("R1 R2 lane bit27");
    // R5 write mode off: same-cycle word still audio
    aud_cfg_wr = 1; aud_cfg_val = 0; aud_bit = 1; ctl_pin = 0;
    step("R5 write edge");
    aud_cfg_wr = 0; aud_bit = 1; ctl_pin = 0;
    step("R4 ctl fallback");
    aud_bit = 0; ctl_pin = 1;
    step("R4 aud ignored");
    // R8 hold when disabled
    frame_en = 0; pix_data = 29'h1555_5555; fwd_bit = 0;
    step("R8 idle hold");
    step("R8 idle hold 2");
    // R7 all ones
    frame_en = 1; aud_cfg_wr = 1; aud_cfg_val = 1; pix_data = '1; alt_sel = 0;
    aud_bit = 1; ctl_pin = 1; fwd_bit = 1;
    step("R7 all ones");
    aud_cfg_wr = 0; pix_data = '0; aud_bit = 0; ctl_pin = 0; fwd_bit = 0;
    step("R7 all zeros");

    for (int v = 0; v < 400; v++) begin
      frame_en    = ($urandom % 8) != 0;
      pix_data    = PW'($urandom);
      alt_sel     = $urandom % 2;
      alt_pin     = $urandom % 2;
      aud_cfg_wr  = ($urandom % 16) == 0;
      aud_cfg_val = $urandom % 2;
      aud_bit     = $urandom % 2;
      ctl_pin     = $urandom % 2;
      fwd_bit     = $urandom % 2;
      step("R1 R3 R4 R6 R7 random");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule